// File: doc/BRIEF.md
# In-Order Commit and Redirect Controller

This block sits at the back end of an out-of-order pipeline. It looks at a small window at the head of the reorder buffer and retires finished instructions in program order, up to a set number each cycle. An instruction that must not run speculatively is held until it reaches the head of the buffer. The block then releases it to execution by announcing its sequence number, and counts the stall. The buffer storage itself lies outside the block.

Execution can send several squash requests in one cycle. The block compares each against the sequence number of the youngest instruction still valid in the buffer, takes the oldest request that qualifies, and broadcasts it to the earlier stages with its target and taken flag. The thread then waits in a squashing state until the buffer reports that it has dropped the squashed entries, which may take several cycles. A trap request makes the thread wait a fixed number of cycles and then squash everything in flight. The block also tells the earlier stages how many buffer entries are free, but only in cycles when the occupancy changed.

The thread state machine has three states, encoded on `thr_state`. RUN (0) is normal retirement. SQUASH (1) waits for the buffer to finish dropping entries. TRAP (2) counts down the trap latency. The transitions are:
- RUN to SQUASH on an accepted redirect.
- RUN to TRAP on a trap request.
- SQUASH to SQUASH on a newly accepted redirect.
- SQUASH to RUN on `rob_sq_done` when no redirect is accepted.
- TRAP to SQUASH when the countdown expires and the squash-all is broadcast.

Top module: `commit_ctrl`

## Requirements
- R1: Slot i of the head window retires (`ret_mask[i]`=1) exactly when the following all hold in that cycle: every slot from 0 to i is valid and done; none of slots 1 to i is flagged non-speculative; the state is RUN; no redirect is accepted; `trap_req` is low. `ret_mask` is therefore always a contiguous run starting at bit 0.
- R2: A valid, non-speculative, not-done instruction in slot 0 raises `ns_rel` for one cycle, with its `head_seq` on `ns_seq`. This happens only while retirement is allowed, and only once per instruction. Each release adds 1 to `stall_count` at the following edge.
- R3: A non-speculative instruction in any slot other than 0 blocks the retirement of itself and of every younger slot.
- R4: A redirect is accepted only if its sequence number is strictly below the tracked youngest sequence number (unsigned). Among several qualifying requests, the lowest sequence number wins. The broadcast raises `sq_valid` in the same cycle with that request's sequence number, target and taken flag, and with `sq_all`=0.
- R5: The tracked youngest sequence number is 0 after reset. It takes `ins_seq` when `ins_valid` is high in a RUN cycle without a broadcast. It takes the broadcast sequence number in any cycle with a broadcast.
- R6: After a broadcast the state is SQUASH. In SQUASH nothing retires, and the state returns to RUN only after a cycle with `rob_sq_done` high and no accepted redirect. A redirect that qualifies during SQUASH is still accepted.
- R7: A `trap_req` in RUN, with no redirect accepted, blocks retirement in that cycle and moves the state to TRAP. Exactly TRAP_LAT cycles after the request cycle, the block broadcasts with `sq_all`=1 and sequence, target and taken all 0. It then enters SQUASH, and the youngest sequence number becomes 0. Redirects are ignored while in TRAP.
- R8: `free_valid` is high only in a cycle where `rob_used` differs from its value in the previous cycle. `free_count` is always DEPTH minus `rob_used`.
- R9: `active` is high exactly when, in that cycle, any slot retires, a squash is broadcast, a non-speculative release occurs, or `free_valid` is high.
- R10: After reset the state is RUN, `stall_count` is 0, and every pulse output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hd_valid | input | CW | Head window slot holds an instruction (slot 0 is oldest) |
| hd_done | input | CW | Slot's instruction has completed execution |
| hd_nonspec | input | CW | Slot's instruction is non-speculative |
| head_seq | input | SEQ_W | Sequence number of the instruction in slot 0 |
| ins_valid | input | 1 | An instruction was inserted into the buffer |
| ins_seq | input | SEQ_W | Sequence number of the inserted instruction |
| rd_valid | input | NR | Redirect request valid, one per source |
| rd_seq | input | NR*SEQ_W | Sequence number to squash back to, per source |
| rd_target | input | NR*TGT_W | Corrected fetch target, per source |
| rd_taken | input | NR | Branch taken flag, per source |
| trap_req | input | 1 | Trap raised for the thread |
| rob_sq_done | input | 1 | Buffer has finished dropping squashed entries |
| rob_used | input | CNT_W | Current buffer occupancy |
| ret_mask | output | CW | Slots retiring this cycle |
| ns_rel | output | 1 | Release pulse for the non-speculative head instruction |
| ns_seq | output | SEQ_W | Sequence number released |
| sq_valid | output | 1 | Squash broadcast |
| sq_seq | output | SEQ_W | Squash-to sequence number |
| sq_target | output | TGT_W | Redirect target |
| sq_taken | output | 1 | Taken flag of the redirecting branch |
| sq_all | output | 1 | Broadcast squashes all in-flight instructions (trap) |
| free_valid | output | 1 | Free-entry count is being reported |
| free_count | output | CNT_W | Number of free buffer entries |
| stall_count | output | STALL_W | Number of non-speculative releases so far |
| thr_state | output | 2 | Thread state: 0 RUN, 1 SQUASH, 2 TRAP |
| active | output | 1 | Any activity this cycle |

## Verification
The assertions check, on every cycle, the properties that hold whatever the stimulus. They confirm that `ret_mask` is a prefix and stays empty during broadcasts and outside RUN. They confirm that every broadcast redirect is older than the tracked youngest number, and that the youngest number follows the broadcast. They also cover the conditions that allow a release, that a squash-all appears only in TRAP, and that no free report appears while occupancy is steady. The bench scenarios cover what only sequences can show:
- oldest-wins arbitration between two sources;
- rejection of equal sequence numbers;
- re-acceptance during SQUASH;
- the exact trap latency;
- the single release per instruction with its stall counter;
- the effect of insertions on which later redirects pass.

// File: rtl/commit_pkg.sv
package commit_pkg;
    typedef enum logic [1:0] {
        TS_RUN    = 2'd0,
        TS_SQUASH = 2'd1,
        TS_TRAP   = 2'd2
    } thr_state_e;
endpackage

// File: rtl/commit_retire_sel.sv
module commit_retire_sel #(
    parameter int CW = 2
) (
    input  logic          en,
    input  logic [CW-1:0] v,
    input  logic [CW-1:0] d,
    input  logic [CW-1:0] ns,
    output logic [CW-1:0] ret,
    output logic          ns_cand
);
    // Running AND: a slot retires only if every older slot retires too.
    always_comb begin
        logic run;
        run = en;
        for (int i = 0; i < CW; i++) begin
            if (i == 0) run = run & v[i] & d[i];
            else        run = run & v[i] & d[i] & ~ns[i];
            ret[i] = run;
        end
    end

    // A non-speculative head that has not finished yet waits to be released.
    assign ns_cand = v[0] & ns[0] & ~d[0];
endmodule

// File: rtl/commit_redir_arb.sv
module commit_redir_arb #(
    parameter int NR    = 2,
    parameter int SEQ_W = 16,
    parameter int TGT_W = 32
) (
    input  logic [NR-1:0]       rd_valid,
    input  logic [NR*SEQ_W-1:0] rd_seq,
    input  logic [NR*TGT_W-1:0] rd_target,
    input  logic [NR-1:0]       rd_taken,
    input  logic [SEQ_W-1:0]    youngest,
    output logic                win_valid,
    output logic [SEQ_W-1:0]    win_seq,
    output logic [TGT_W-1:0]    win_target,
    output logic                win_taken
);
    // Keep only requests older than the youngest valid entry; the oldest of them wins.
    always_comb begin
        win_valid  = 1'b0;
        win_seq    = '0;
        win_target = '0;
        win_taken  = 1'b0;
        for (int i = 0; i < NR; i++) begin
            if (rd_valid[i] && (rd_seq[i*SEQ_W +: SEQ_W] < youngest) &&
                (!win_valid || (rd_seq[i*SEQ_W +: SEQ_W] < win_seq))) begin
                win_valid  = 1'b1;
                win_seq    = rd_seq[i*SEQ_W +: SEQ_W];
                win_target = rd_target[i*TGT_W +: TGT_W];
                win_taken  = rd_taken[i];
            end
        end
    end
endmodule

// File: rtl/commit_free_track.sv
module commit_free_track #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rob_used,
    output logic             free_valid,
    output logic [CNT_W-1:0] free_count
);
    logic [CNT_W-1:0] used_q;

    always_ff @(posedge clk) begin
        if (!rst_n) used_q <= '0;
        else        used_q <= rob_used;
    end

    assign free_valid = (rob_used != used_q);
    assign free_count = CNT_W'(DEPTH) - rob_used;
endmodule

// File: rtl/commit_ctrl.sv
module commit_ctrl #(
    parameter int CW       = 2,
    parameter int NR       = 2,
    parameter int SEQ_W    = 16,
    parameter int TGT_W    = 32,
    parameter int DEPTH    = 16,
    parameter int TRAP_LAT = 3,
    parameter int STALL_W  = 16,
    parameter int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CW-1:0]       hd_valid,
    input  logic [CW-1:0]       hd_done,
    input  logic [CW-1:0]       hd_nonspec,
    input  logic [SEQ_W-1:0]    head_seq,
    input  logic                ins_valid,
    input  logic [SEQ_W-1:0]    ins_seq,
    input  logic [NR-1:0]       rd_valid,
    input  logic [NR*SEQ_W-1:0] rd_seq,
    input  logic [NR*TGT_W-1:0] rd_target,
    input  logic [NR-1:0]       rd_taken,
    input  logic                trap_req,
    input  logic                rob_sq_done,
    input  logic [CNT_W-1:0]    rob_used,
    output logic [CW-1:0]       ret_mask,
    output logic                ns_rel,
    output logic [SEQ_W-1:0]    ns_seq,
    output logic                sq_valid,
    output logic [SEQ_W-1:0]    sq_seq,
    output logic [TGT_W-1:0]    sq_target,
    output logic                sq_taken,
    output logic                sq_all,
    output logic                free_valid,
    output logic [CNT_W-1:0]    free_count,
    output logic [STALL_W-1:0]  stall_count,
    output logic [1:0]          thr_state,
    output logic                active
);
    import commit_pkg::*;

    localparam int TL_W = $clog2(TRAP_LAT + 1);

    thr_state_e          state_q, state_d;
    logic [TL_W-1:0]     cnt_q;
    logic [SEQ_W-1:0]    youngest_q;
    logic                rel_done_q;
    logic [SEQ_W-1:0]    rel_seq_q;
    logic [STALL_W-1:0]  stall_q;

    logic                arb_valid;
    logic [SEQ_W-1:0]    arb_seq;
    logic [TGT_W-1:0]    arb_target;
    logic                arb_taken;
    logic                acc;
    logic                trap_fire;
    logic                ret_en;
    logic                ns_cand;

    commit_redir_arb #(.NR(NR), .SEQ_W(SEQ_W), .TGT_W(TGT_W)) u_arb (
        .rd_valid   (rd_valid),
        .rd_seq     (rd_seq),
        .rd_target  (rd_target),
        .rd_taken   (rd_taken),
        .youngest   (youngest_q),
        .win_valid  (arb_valid),
        .win_seq    (arb_seq),
        .win_target (arb_target),
        .win_taken  (arb_taken)
    );

    commit_retire_sel #(.CW(CW)) u_sel (
        .en      (ret_en),
        .v       (hd_valid),
        .d       (hd_done),
        .ns      (hd_nonspec),
        .ret     (ret_mask),
        .ns_cand (ns_cand)
    );

    commit_free_track #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_free (
        .clk        (clk),
        .rst_n      (rst_n),
        .rob_used   (rob_used),
        .free_valid (free_valid),
        .free_count (free_count)
    );

    // Decision and output process
    always_comb begin
        acc       = arb_valid && (state_q != TS_TRAP);
        trap_fire = (state_q == TS_TRAP) && (cnt_q == TL_W'(1));
        ret_en    = (state_q == TS_RUN) && !acc && !trap_req;

        ns_rel    = ret_en && ns_cand && !(rel_done_q && (rel_seq_q == head_seq));
        ns_seq    = ns_rel ? head_seq : '0;

        sq_valid  = acc || trap_fire;
        sq_all    = trap_fire;
        sq_seq    = trap_fire ? '0 : (acc ? arb_seq    : '0);
        sq_target = trap_fire ? '0 : (acc ? arb_target : '0);
        sq_taken  = trap_fire ? 1'b0 : (acc && arb_taken);

        active    = (|ret_mask) || sq_valid || ns_rel || free_valid;

        state_d = state_q;
        unique case (state_q)
            TS_RUN: begin
                if (acc)           state_d = TS_SQUASH;
                else if (trap_req) state_d = TS_TRAP;
            end
            TS_SQUASH: begin
                if (!acc && rob_sq_done) state_d = TS_RUN;
            end
            TS_TRAP: begin
                if (trap_fire) state_d = TS_SQUASH;
            end
            default: state_d = TS_RUN;
        endcase
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= TS_RUN;
            cnt_q      <= '0;
            youngest_q <= '0;
            rel_done_q <= 1'b0;
            rel_seq_q  <= '0;
            stall_q    <= '0;
        end else begin
            state_q <= state_d;

            if (state_q == TS_RUN && !acc && trap_req) cnt_q <= TL_W'(TRAP_LAT);
            else if (state_q == TS_TRAP)               cnt_q <= cnt_q - 1'b1;

            if (sq_valid)                          youngest_q <= sq_seq;
            else if (state_q == TS_RUN && ins_valid) youngest_q <= ins_seq;

            if (sq_valid) begin
                rel_done_q <= 1'b0;
            end else if (ns_rel) begin
                rel_done_q <= 1'b1;
                rel_seq_q  <= head_seq;
            end

            if (ns_rel) stall_q <= stall_q + 1'b1;
        end
    end

    assign stall_count = stall_q;
    assign thr_state   = state_q;
endmodule

// File: rtl/commit_ctrl_chk.sv
module commit_ctrl_chk #(
    parameter int CW    = 2,
    parameter int SEQ_W = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CW-1:0]    ret_mask,
    input logic             sq_valid,
    input logic             sq_all,
    input logic [SEQ_W-1:0] sq_seq,
    input logic [SEQ_W-1:0] youngest,
    input logic [1:0]       state,
    input logic             ns_rel,
    input logic [CW-1:0]    hd_valid,
    input logic [CW-1:0]    hd_done,
    input logic [CW-1:0]    hd_nonspec,
    input logic             free_valid,
    input logic [CNT_W-1:0] rob_used
);
    import commit_pkg::*;

    assert_retire_prefix_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_mask & (ret_mask + 1'b1)) == '0);

    assert_no_retire_squash_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_valid || state != TS_RUN) |-> ret_mask == '0);

    assert_release_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ns_rel |-> (hd_valid[0] && hd_nonspec[0] && !hd_done[0] && state == TS_RUN));

    assert_redirect_older_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_valid && !sq_all) |-> (sq_seq < youngest));

    assert_youngest_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid |=> (youngest == $past(sq_seq)));

    assert_trap_squash_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sq_all |-> (state == TS_TRAP && sq_seq == '0));

    assert_free_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && rob_used == $past(rob_used)) |-> !free_valid);
endmodule

bind commit_ctrl commit_ctrl_chk #(.CW(CW), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ret_mask   (ret_mask),
    .sq_valid   (sq_valid),
    .sq_all     (sq_all),
    .sq_seq     (sq_seq),
    .youngest   (youngest_q),
    .state      (state_q),
    .ns_rel     (ns_rel),
    .hd_valid   (hd_valid),
    .hd_done    (hd_done),
    .hd_nonspec (hd_nonspec),
    .free_valid (free_valid),
    .rob_used   (rob_used)
);

// File: tb/commit_ctrl_tb.sv
module commit_ctrl_tb;
    localparam int CW = 2, NR = 2, SEQ_W = 16, TGT_W = 32, DEPTH = 16, TRAP_LAT = 3;
    localparam int STALL_W = 16, CNT_W = 5;

    logic clk = 0;
    logic rst_n = 0;
    always #2.5 clk = ~clk;

    logic [CW-1:0]       hd_valid, hd_done, hd_nonspec;
    logic [SEQ_W-1:0]    head_seq, ins_seq;
    logic                ins_valid, trap_req, rob_sq_done;
    logic [NR-1:0]       rd_valid, rd_taken;
    logic [NR*SEQ_W-1:0] rd_seq;
    logic [NR*TGT_W-1:0] rd_target;
    logic [CNT_W-1:0]    rob_used;
    logic [CW-1:0]       ret_mask;
    logic                ns_rel, sq_valid, sq_taken, sq_all, free_valid, active;
    logic [SEQ_W-1:0]    ns_seq, sq_seq;
    logic [TGT_W-1:0]    sq_target;
    logic [CNT_W-1:0]    free_count;
    logic [STALL_W-1:0]  stall_count;
    logic [1:0]          thr_state;

    commit_ctrl #(.CW(CW), .NR(NR), .SEQ_W(SEQ_W), .TGT_W(TGT_W), .DEPTH(DEPTH),
                  .TRAP_LAT(TRAP_LAT), .STALL_W(STALL_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .hd_valid(hd_valid), .hd_done(hd_done),
        .hd_nonspec(hd_nonspec), .head_seq(head_seq), .ins_valid(ins_valid),
        .ins_seq(ins_seq), .rd_valid(rd_valid), .rd_seq(rd_seq), .rd_target(rd_target),
        .rd_taken(rd_taken), .trap_req(trap_req), .rob_sq_done(rob_sq_done),
        .rob_used(rob_used), .ret_mask(ret_mask), .ns_rel(ns_rel), .ns_seq(ns_seq),
        .sq_valid(sq_valid), .sq_seq(sq_seq), .sq_target(sq_target), .sq_taken(sq_taken),
        .sq_all(sq_all), .free_valid(free_valid), .free_count(free_count),
        .stall_count(stall_count), .thr_state(thr_state), .active(active)
    );

    typedef struct packed {
        logic [CW-1:0]      ret;
        logic               nsr;
        logic [SEQ_W-1:0]   nss;
        logic               sqv;
        logic [SEQ_W-1:0]   sqs;
        logic [TGT_W-1:0]   sqt;
        logic               sqk;
        logic               sqa;
        logic               frv;
        logic [CNT_W-1:0]   frc;
        logic [1:0]         st;
        logic               act;
        logic [STALL_W-1:0] stl;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    errors = 0;
    int    checks = 0;
    bit    finished = 0;

    task automatic push(exp_t e, string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    function automatic exp_t mk(logic [CW-1:0] r, logic [1:0] st, logic act, int stl);
        exp_t e = '0;
        e.ret = r; e.st = st; e.act = act; e.stl = STALL_W'(stl);
        e.frc = CNT_W'(DEPTH) - rob_used;
        return e;
    endfunction

    task automatic clr();
        hd_valid = '0; hd_done = '0; hd_nonspec = '0; head_seq = '0;
        ins_valid = 0; ins_seq = '0; rd_valid = '0; rd_seq = '0; rd_target = '0;
        rd_taken = '0; trap_req = 0; rob_sq_done = 0;
    endtask

    task automatic head(logic [1:0] v, logic [1:0] d, logic [1:0] ns, int s0);
        hd_valid = v; hd_done = d; hd_nonspec = ns; head_seq = SEQ_W'(s0);
    endtask

    task automatic redir(int idx, int s, int t, logic k);
        rd_valid[idx] = 1'b1;
        rd_seq[idx*SEQ_W +: SEQ_W] = SEQ_W'(s);
        rd_target[idx*TGT_W +: TGT_W] = TGT_W'(t);
        rd_taken[idx] = k;
    endtask

    // Monitor: pops one expected item per cycle and compares mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e, a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {ret_mask, ns_rel, ns_seq, sq_valid, sq_seq, sq_target, sq_taken,
                     sq_all, free_valid, free_count, thr_state, active, stall_count};
                checks++;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", t, a, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        exp_t e;
        clr(); rob_used = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // C1 reset state, R10
        clr(); push(mk(2'b00, 2'd0, 0, 0), "R10 reset state");
        // C2 full retire, occupancy change, insert youngest 20 (R1, R8, R9)
        @(negedge clk); clr(); head(2'b11, 2'b11, 2'b00, 10); rob_used = 5;
        ins_valid = 1; ins_seq = 20;
        e = mk(2'b11, 0, 1, 0); e.frv = 1; push(e, "R1 R8 full retire");
        // C3 slot 1 not done
        @(negedge clk); clr(); head(2'b11, 2'b01, 2'b00, 12);
        push(mk(2'b01, 0, 1, 0), "R1 partial retire");
        // C4 slot 0 invalid
        @(negedge clk); clr(); head(2'b10, 2'b11, 2'b00, 12);
        push(mk(2'b00, 0, 0, 0), "R1 R9 empty head");
        // C5 non-speculative in slot 1
        @(negedge clk); clr(); head(2'b11, 2'b11, 2'b10, 12);
        push(mk(2'b01, 0, 1, 0), "R3 nonspec slot 1 blocks");
        // C6 non-speculative head release
        @(negedge clk); clr(); head(2'b01, 2'b00, 2'b01, 13);
        e = mk(2'b00, 0, 1, 0); e.nsr = 1; e.nss = 13; push(e, "R2 release");
        // C7 same head: no second release
        @(negedge clk); clr(); head(2'b01, 2'b00, 2'b01, 13);
        push(mk(2'b00, 0, 0, 1), "R2 release once");
        // C8 head completes
        @(negedge clk); clr(); head(2'b01, 2'b01, 2'b01, 13);
        push(mk(2'b01, 0, 1, 1), "R2 nonspec retires");
        // C9 two redirects, oldest wins
        @(negedge clk); clr(); head(2'b11, 2'b11, 2'b00, 14);
        redir(0, 18, 'h100, 1); redir(1, 15, 'h200, 0);
        e = mk(2'b00, 0, 1, 1); e.sqv = 1; e.sqs = 15; e.sqt = 'h200;
        push(e, "R4 oldest redirect wins");
        // C10 squashing, younger redirect ignored
        @(negedge clk); clr(); head(2'b11, 2'b11, 2'b00, 14); redir(0, 16, 'h5, 1);
        push(mk(2'b00, 1, 0, 1), "R6 R4 squashing ignore younger");
        // C11 equal seq ignored, rob done
        @(negedge clk); clr(); redir(0, 15, 'h5, 1); rob_sq_done = 1;
        push(mk(2'b00, 1, 0, 1), "R4 equal seq rejected");
        // C12 back in RUN, insert 30
        @(negedge clk); clr(); ins_valid = 1; ins_seq = 30;
        push(mk(2'b00, 0, 0, 1), "R6 return to run");
        // C13 redirect equal to youngest ignored
        @(negedge clk); clr(); redir(0, 30, 'h6, 0);
        push(mk(2'b00, 0, 0, 1), "R5 youngest from insert");
        // C14 older accepted via source 1
        @(negedge clk); clr(); redir(1, 29, 'h3, 1);
        e = mk(2'b00, 0, 1, 1); e.sqv = 1; e.sqs = 29; e.sqt = 'h3; e.sqk = 1;
        push(e, "R4 R5 accept older");
        // C15 accepted during squash, overrides done
        @(negedge clk); clr(); redir(0, 25, 'h4, 0); rob_sq_done = 1;
        e = mk(2'b00, 1, 1, 1); e.sqv = 1; e.sqs = 25; e.sqt = 'h4;
        push(e, "R6 reaccept in squash");
        // C16 done
        @(negedge clk); clr(); rob_sq_done = 1;
        push(mk(2'b00, 1, 0, 1), "R6 squash done");
        // C17 trap request blocks retire
        @(negedge clk); clr(); head(2'b11, 2'b11, 2'b00, 20); trap_req = 1;
        push(mk(2'b00, 0, 0, 1), "R7 trap blocks retire");
        // C18..C19 waiting, redirect ignored
        @(negedge clk); clr(); head(2'b11, 2'b11, 2'b00, 20); redir(0, 1, 'h9, 1);
        push(mk(2'b00, 2, 0, 1), "R7 trap ignores redirect");
        @(negedge clk); clr(); head(2'b11, 2'b11, 2'b00, 20);
        push(mk(2'b00, 2, 0, 1), "R7 trap wait");
        // C20 squash-all
        @(negedge clk); clr();
        e = mk(2'b00, 2, 1, 1); e.sqv = 1; e.sqa = 1; push(e, "R7 squash all");
        // C21
        @(negedge clk); clr(); rob_sq_done = 1;
        push(mk(2'b00, 1, 0, 1), "R7 squash after trap");
        // C22 youngest now 0: redirect 0 rejected; insert 40
        @(negedge clk); clr(); redir(0, 0, 'h7, 0); ins_valid = 1; ins_seq = 40;
        push(mk(2'b00, 0, 0, 1), "R5 youngest zero after trap");
        // C23
        @(negedge clk); clr(); redir(0, 39, 'h8, 1);
        e = mk(2'b00, 0, 1, 1); e.sqv = 1; e.sqs = 39; e.sqt = 'h8; e.sqk = 1;
        push(e, "R5 accept after insert");
        // C24
        @(negedge clk); clr(); rob_sq_done = 1;
        push(mk(2'b00, 1, 0, 1), "R6 done again");
        // C25 occupancy change
        @(negedge clk); clr(); rob_used = 7;
        e = mk(2'b00, 0, 1, 1); e.frv = 1; push(e, "R8 R9 free report");
        // C26 steady occupancy
        @(negedge clk); clr();
        push(mk(2'b00, 0, 0, 1), "R8 quiet when steady");
        // C27 second release
        @(negedge clk); clr(); head(2'b01, 2'b00, 2'b01, 50);
        e = mk(2'b00, 0, 1, 1); e.nsr = 1; e.nss = 50; push(e, "R2 second release");
        // C28 stall counter
        @(negedge clk); clr();
        push(mk(2'b00, 0, 0, 2), "R2 stall count");

        @(negedge clk); clr();
        #2;
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule